// File: doc/BRIEF.md
# Operand Address Generator for a Three-Address Machine

This block resolves one 12-bit operand field of a 48-bit three-address instruction into a 16-bit memory address. Every full address is a 5-bit bank number followed by an 11-bit word offset. The field selects one of five modes:

- **Direct:** an 11-bit word offset inside the current bank.
- **Indexed:** one of eight index registers plus a 7-bit offset.
- **Register-indirect:** the named register holds the address and is bumped after use.
- **Register-direct:** the named register is itself the operand, with the same optional bump.
- **Inactive:** no access at all.

The program's 32-entry control register file sits outside the block. The block drives a read index and takes the register value back in the same cycle. It returns any post-increment as a write strobe with index and data. The strobe fires in the cycle in which the resolved address is handed on.

Requests enter with a valid/ready handshake. Results leave from one output register with its own valid/ready handshake. If the pending write-back in the output register targets the same register that an incoming field reads, the pending value is forwarded to the incoming field. Back-to-back pointer walks therefore run at one field per cycle.

Top module: `opnd_addr_gen`

## Requirements
- R1: A field with bit 11 set resolves to the address {bank, field[10:0]}, where bank is the input bank number. It flags a memory operand and requests no write-back.
- R2: A field with bits [11:10] = 01 reads index register 16+field[9:7] and resolves to that register plus the zero-extended field[6:0]. It flags a memory operand and requests no write-back.
- R3: A field with bits [11:10] = 00, bit 9 = 1 and a legal step code is register-indirect. It reads register field[8:4], resolves to that register's value, and writes back the value plus the step.
- R4: A field with bits [11:10] = 00, bit 9 = 0 and a legal step code is register-direct, unless the whole field is zero. It resolves to the register number field[8:4] zero-extended, sets the register flag, and writes back the register value plus the step.
- R5: The step code field[3:0] maps codes 0..8 to steps 0..8 and codes 9..14 to steps 12, 16, 20, 24, 28 and 32. Code 15 in a register-based field is illegal: the result carries the error flag, address 0, and no write-back.
- R6: All address sums (index plus offset, register plus step) are 16-bit. A carry out of the word offset runs into the bank number, and the sum wraps at 65536.
- R7: An all-zero field is inactive. The result carries the inactive flag, address 0, no register flag and no write-back.
- R8: A register-based field whose step is 0 requests no write-back.
- R9: The write strobe is high only in a cycle in which out_valid and out_ready are both high. In that cycle it carries the index and incremented value belonging to the presented result.
- R10: in_ready is high exactly when the output register is empty or being drained. While out_valid is high and out_ready is low, every output holds its value.
- R11: A field that reads a register with a write-back still pending in the output register sees the incremented value, not the stale file value.
- R12: After reset the output register is empty: out_valid and the write strobe are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand field offered |
| in_ready | output | 1 | Block can take a field this cycle |
| in_field | input | 12 | Operand address field |
| in_bank | input | 5 | Bank of the running segment, used by direct mode |
| rd_idx | output | 5 | Register file read index |
| rd_data | input | 16 | Register file read value for rd_idx |
| out_valid | output | 1 | Resolved operand present |
| out_ready | input | 1 | Consumer takes the resolved operand |
| out_ea | output | 16 | Resolved address, or register number in register-direct mode |
| out_is_reg | output | 1 | Operand is a register, not a memory word |
| out_inactive | output | 1 | Field was inactive |
| out_err | output | 1 | Field carried an illegal step code |
| wb_we | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Register written back |
| wb_data | output | 16 | Incremented register value |

## Verification
The bench aims at the carry from word offset into bank and at the 16-bit wrap. A design that truncated to 11 bits would lose the bank change, and one that stopped at the bank field would miss the wrap to zero. It issues two bumps of the same pointer back to back to exercise forwarding. Without forwarding, both bumps would use the same stale value and one increment would be lost in the external file. Stalls with out_ready low catch results that change while held or strobes that fire early. The illegal step code and zero steps catch spurious register writes.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  parameter int unsigned OA_BANK_W  = 5;
  parameter int unsigned OA_WORD_W  = 11;
  parameter int unsigned OA_ADDR_W  = OA_BANK_W + OA_WORD_W;
  parameter int unsigned OA_FIELD_W = OA_WORD_W + 1;
  parameter int unsigned OA_RIDX_W  = 5;
  parameter int unsigned OA_XSEL_W  = 3;
  parameter int unsigned OA_OFS_W   = 7;
  parameter int unsigned OA_CODE_W  = 4;
  parameter int unsigned OA_STEP_W  = 6;
  parameter int unsigned OA_XBASE   = 16;

  typedef enum logic [2:0] {
    AM_NONE,
    AM_DIRECT,
    AM_INDEX,
    AM_IND,
    AM_REGDIR,
    AM_BAD
  } amode_e;

  typedef struct packed {
    logic [OA_ADDR_W-1:0] ea;
    logic                 is_reg;
    logic                 inactive;
    logic                 err;
    logic                 wb_pend;
    logic [OA_RIDX_W-1:0] wb_idx;
    logic [OA_ADDR_W-1:0] wb_data;
  } oa_res_t;

  // Step table: linear up to 8, then coarse steps of 4 up to 32.
  function automatic logic [OA_STEP_W-1:0] oa_step(input logic [OA_CODE_W-1:0] c);
    logic [OA_STEP_W-1:0] s;
    case (c)
      4'd9:    s = 6'd12;
      4'd10:   s = 6'd16;
      4'd11:   s = 6'd20;
      4'd12:   s = 6'd24;
      4'd13:   s = 6'd28;
      4'd14:   s = 6'd32;
      4'd15:   s = 6'd0;
      default: s = {{(OA_STEP_W-OA_CODE_W){1'b0}}, c};
    endcase
    return s;
  endfunction

  function automatic logic oa_code_legal(input logic [OA_CODE_W-1:0] c);
    return c != {OA_CODE_W{1'b1}};
  endfunction

  // Full-width address sum; a carry out of the word offset enters the bank.
  function automatic logic [OA_ADDR_W-1:0] oa_add(input logic [OA_ADDR_W-1:0] a,
                                                  input logic [OA_ADDR_W-1:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/opnd_addr_decode.sv
module opnd_addr_decode
  import opnd_addr_pkg::*;
(
  input  logic [OA_FIELD_W-1:0] field,
  output amode_e                mode,
  output logic [OA_RIDX_W-1:0]  reg_sel,
  output logic [OA_STEP_W-1:0]  step,
  output logic [OA_WORD_W-1:0]  word,
  output logic [OA_OFS_W-1:0]   ofs
);

  localparam int unsigned TOP    = OA_FIELD_W - 1;
  localparam int unsigned XS_LO  = OA_OFS_W;
  localparam int unsigned XS_HI  = OA_OFS_W + OA_XSEL_W - 1;
  localparam int unsigned RN_LO  = OA_CODE_W;
  localparam int unsigned RN_HI  = OA_CODE_W + OA_RIDX_W - 1;
  localparam int unsigned SUBBIT = RN_HI + 1;

  logic [OA_CODE_W-1:0] code;
  logic [OA_XSEL_W-1:0] xsel;

  assign code = field[OA_CODE_W-1:0];
  assign xsel = field[XS_HI:XS_LO];
  assign word = field[OA_WORD_W-1:0];
  assign ofs  = field[OA_OFS_W-1:0];
  assign step = oa_step(code);

  always_comb begin
    if (field[TOP])                   mode = AM_DIRECT;
    else if (field[TOP-1])            mode = AM_INDEX;
    else if (field == '0)             mode = AM_NONE;
    else if (!oa_code_legal(code))    mode = AM_BAD;
    else if (field[SUBBIT])           mode = AM_IND;
    else                              mode = AM_REGDIR;
  end

  always_comb begin
    if (mode == AM_INDEX)
      reg_sel = OA_RIDX_W'(OA_XBASE) + {{(OA_RIDX_W-OA_XSEL_W){1'b0}}, xsel};
    else
      reg_sel = field[RN_HI:RN_LO];
  end

endmodule

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
  import opnd_addr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_fire,
  input  amode_e                mode,
  input  logic [OA_RIDX_W-1:0]  reg_sel,
  input  logic [OA_STEP_W-1:0]  step,
  input  logic [OA_WORD_W-1:0]  word,
  input  logic [OA_OFS_W-1:0]   ofs,
  input  logic [OA_BANK_W-1:0]  bank,
  input  logic [OA_ADDR_W-1:0]  rd_data,
  input  logic                  fwd_en,
  input  logic [OA_RIDX_W-1:0]  fwd_idx,
  input  logic [OA_ADDR_W-1:0]  fwd_data,
  output logic                  fwd_hit,
  output oa_res_t               res
);

  localparam int unsigned OFS_PAD  = OA_ADDR_W - OA_OFS_W;
  localparam int unsigned STEP_PAD = OA_ADDR_W - OA_STEP_W;
  localparam int unsigned RIDX_PAD = OA_ADDR_W - OA_RIDX_W;

  logic [OA_ADDR_W-1:0] base;
  logic [OA_ADDR_W-1:0] bumped;

  assign fwd_hit = fwd_en && (fwd_idx == reg_sel);
  assign base    = fwd_hit ? fwd_data : rd_data;
  assign bumped  = oa_add(base, {{STEP_PAD{1'b0}}, step});

  always_comb begin
    res         = '0;
    res.wb_idx  = reg_sel;
    res.wb_data = bumped;
    case (mode)
      AM_DIRECT: res.ea = {bank, word};
      AM_INDEX:  res.ea = oa_add(base, {{OFS_PAD{1'b0}}, ofs});
      AM_IND: begin
        res.ea      = base;
        res.wb_pend = step != '0;
      end
      AM_REGDIR: begin
        res.ea      = {{RIDX_PAD{1'b0}}, reg_sel};
        res.is_reg  = 1'b1;
        res.wb_pend = step != '0;
      end
      AM_NONE:   res.inactive = 1'b1;
      default:   res.err      = 1'b1;
    endcase
  end

  p_direct_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && mode == AM_DIRECT |-> res.ea[OA_ADDR_W-1:OA_WORD_W] == bank && !res.wb_pend);

  p_index_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && mode == AM_INDEX |->
      reg_sel >= OA_RIDX_W'(OA_XBASE) && reg_sel < OA_RIDX_W'(OA_XBASE + 8) && !res.wb_pend);

  p_step_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && mode == AM_IND |-> OA_ADDR_W'(res.wb_data - res.ea) == OA_ADDR_W'(step));

  p_bad_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && mode == AM_BAD |-> res.err && !res.wb_pend && res.ea == '0);

  p_zero_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && step == '0 |-> !res.wb_pend);

endmodule

// File: rtl/opnd_addr_stage.sv
module opnd_addr_stage
  import opnd_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  oa_res_t res_d,
  output logic    out_valid,
  input  logic    out_ready,
  output oa_res_t res_q,
  output logic    wb_we
);

  logic vld_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign wb_we     = vld_q && out_ready && res_q.wb_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      res_q <= res_d;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q));

  p_wb_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> out_valid && out_ready);

  p_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_q.inactive |-> res_q.ea == '0 && !res_q.wb_pend && !res_q.is_reg);

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_addr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OA_FIELD_W-1:0] in_field,
  input  logic [OA_BANK_W-1:0]  in_bank,
  output logic [OA_RIDX_W-1:0]  rd_idx,
  input  logic [OA_ADDR_W-1:0]  rd_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OA_ADDR_W-1:0]  out_ea,
  output logic                  out_is_reg,
  output logic                  out_inactive,
  output logic                  out_err,
  output logic                  wb_we,
  output logic [OA_RIDX_W-1:0]  wb_idx,
  output logic [OA_ADDR_W-1:0]  wb_data
);

  amode_e               mode;
  logic [OA_RIDX_W-1:0] reg_sel;
  logic [OA_STEP_W-1:0] step;
  logic [OA_WORD_W-1:0] word;
  logic [OA_OFS_W-1:0]  ofs;
  oa_res_t              res_d;
  oa_res_t              res_q;
  logic                 in_fire;
  logic                 fwd_en;
  logic                 fwd_hit;

  assign in_fire = in_valid && in_ready;
  assign fwd_en  = out_valid && res_q.wb_pend;
  assign rd_idx  = reg_sel;

  opnd_addr_decode u_dec (
    .field   (in_field),
    .mode    (mode),
    .reg_sel (reg_sel),
    .step    (step),
    .word    (word),
    .ofs     (ofs)
  );

  opnd_addr_calc u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (in_fire),
    .mode     (mode),
    .reg_sel  (reg_sel),
    .step     (step),
    .word     (word),
    .ofs      (ofs),
    .bank     (in_bank),
    .rd_data  (rd_data),
    .fwd_en   (fwd_en),
    .fwd_idx  (res_q.wb_idx),
    .fwd_data (res_q.wb_data),
    .fwd_hit  (fwd_hit),
    .res      (res_d)
  );

  opnd_addr_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_d     (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_q     (res_q),
    .wb_we     (wb_we)
  );

  assign out_ea       = res_q.ea;
  assign out_is_reg   = res_q.is_reg;
  assign out_inactive = res_q.inactive;
  assign out_err      = res_q.err;
  assign wb_idx       = res_q.wb_idx;
  assign wb_data      = res_q.wb_data;

  // R11: a forwarded read must pick up the value the pending strobe will write.
  p_fwd_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && fwd_hit && u_dec.mode == AM_IND |-> res_d.ea == wb_data);

endmodule

// File: tb/opnd_addr_gen_bench.sv
`timescale 1ns/1ps
module opnd_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_field = '0;
  logic [4:0]  in_bank = '0;
  logic [4:0]  rd_idx;
  logic [15:0] rd_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_ea;
  logic        out_is_reg, out_inactive, out_err;
  logic        wb_we;
  logic [4:0]  wb_idx;
  logic [15:0] wb_data;

  always #2.5 clk = ~clk;

  opnd_addr_gen u_opnd_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_field(in_field), .in_bank(in_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
    .out_is_reg(out_is_reg), .out_inactive(out_inactive), .out_err(out_err),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // External register file written by the block, plus the bench's own model of it.
  logic [15:0] rf  [32];
  logic [15:0] mrf [32];
  assign rd_data = rf[rd_idx];
  always @(posedge clk) if (wb_we) rf[wb_idx] <= wb_data;

  int n_chk = 0;
  int n_fail = 0;

  logic        e_vld = 1'b0;
  logic [15:0] e_ea;
  logic        e_isr, e_ina, e_err, e_wb;
  logic [4:0]  e_wi;
  logic [15:0] e_wd;
  string       e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int step_of(input logic [3:0] c);
    return (c <= 4'd8) ? int'(c) : 4 * int'(c) - 24;
  endfunction

  // Expected result from the requirements, using the bench's model file.
  task automatic ref_op(input logic [11:0] f, input logic [4:0] b, input string xt);
    logic [15:0] v;
    int s;
    e_ea = '0; e_isr = 0; e_ina = 0; e_err = 0; e_wb = 0; e_wi = '0; e_wd = '0;
    if (f[11]) begin
      e_ea = {b, f[10:0]}; e_tag = {"R1", xt};
    end else if (f[10]) begin
      v = mrf[16 + int'(f[9:7])];
      e_ea = v + {9'd0, f[6:0]}; e_tag = {"R2", xt};
    end else if (f == 12'd0) begin
      e_ina = 1; e_tag = {"R7", xt};
    end else if (f[3:0] == 4'hF) begin
      e_err = 1; e_tag = {"R5", xt};
    end else begin
      s = step_of(f[3:0]);
      v = mrf[f[8:4]];
      e_wi = f[8:4];
      e_wd = v + 16'(s);
      e_wb = (s != 0);
      if (f[9]) begin e_ea = v; e_tag = {"R3", xt}; end
      else begin e_ea = {11'd0, f[8:4]}; e_isr = 1; e_tag = {"R4", xt}; end
      if (s == 0) e_tag = {e_tag, "/R8"};
      if (e_wb) mrf[e_wi] = e_wd;
    end
  endtask

  task automatic step(input bit v, input logic [11:0] f, input logic [4:0] b,
                      input bit rdy, input string xt, output bit acc);
    @(negedge clk);
    in_valid = v; in_field = f; in_bank = b; out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R10", "in_ready", in_ready, !out_valid || out_ready);
    chk(out_valid == e_vld, "R10", "out_valid", out_valid, e_vld);
    if (out_valid && e_vld) begin
      chk(out_ea == e_ea, e_tag, "ea", out_ea, e_ea);
      chk({out_is_reg, out_inactive, out_err} == {e_isr, e_ina, e_err}, e_tag, "flags",
          {out_is_reg, out_inactive, out_err}, {e_isr, e_ina, e_err});
    end
    if (out_valid && out_ready) begin
      chk(wb_we == e_wb, {"R9 ", e_tag}, "wb_we", wb_we, e_wb);
      if (e_wb) begin
        chk(wb_idx == e_wi, {"R9 ", e_tag}, "wb_idx", wb_idx, e_wi);
        chk(wb_data == e_wd, {"R9 ", e_tag}, "wb_data", wb_data, e_wd);
      end
      e_vld = 0;
    end else begin
      chk(wb_we == 1'b0, "R9", "wb_we idle", wb_we, 0);
    end
    acc = v && in_ready;
    if (acc) begin
      ref_op(f, b, xt);
      e_vld = 1;
    end
  endtask

  task automatic issue(input logic [11:0] f, input logic [4:0] b, input string xt);
    bit acc;
    for (int i = 0; i < 50; i++) begin
      step(1'b1, f, b, 1'b1, xt, acc);
      if (acc) return;
    end
    chk(0, xt, "issue never accepted", 0, 1);
  endtask

  task automatic drain(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 12'd0, 5'd0, 1'b1, "", acc);
  endtask

  task automatic set_reg(input int r, input logic [15:0] v);
    rf[r] = v; mrf[r] = v;
  endtask

  function automatic logic [11:0] rfield(input int m, input logic [31:0] r);
    case (m)
      0: return {1'b1, r[10:0]};
      1: return {2'b01, r[9:0]};
      2: return {2'b00, 1'b1, r[8:0]};
      3: return {2'b00, 1'b0, r[8:0]};
      default: return (r[0]) ? 12'd0 : {3'b000, r[8:4], 4'hF};
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit acc;
    int unused;
    unused = $urandom(32'h5eed_0a11);
    for (int i = 0; i < 32; i++) set_reg(i, 16'($urandom));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    // R12: empty after reset
    chk(out_valid == 1'b0, "R12", "out_valid", out_valid, 0);
    chk(wb_we == 1'b0, "R12", "wb_we", wb_we, 0);
    chk(in_ready == 1'b1, "R12", "in_ready", in_ready, 1);

    issue({1'b1, 11'h5A3}, 5'd7, "");                     // R1
    set_reg(19, 16'hFFF0);
    issue({2'b01, 3'd3, 7'h7F}, 5'd2, " R6 wrap idx");   // R2 R6: 0xFFF0+0x7F -> 0x006F
    set_reg(4, 16'h07FF);
    issue({2'b00, 1'b1, 5'd4, 4'd14}, 5'd0, " R6 bank carry"); // R3 R5: step 32, 0x081F
    set_reg(6, 16'hFFFF);
    issue({2'b00, 1'b1, 5'd6, 4'd1}, 5'd0, " R6 wrap");  // wb 0x0000
    issue({2'b00, 1'b1, 5'd9, 4'hF}, 5'd0, "");           // R5 illegal
    issue(12'd0, 5'd3, "");                                // R7
    issue({2'b00, 1'b1, 5'd9, 4'd0}, 5'd0, "");           // R8
    issue({2'b00, 1'b0, 5'd20, 4'd9}, 5'd0, "");          // R4 step 12
    drain(2);
    // R11: back-to-back bumps of the same pointer
    issue({2'b00, 1'b1, 5'd4, 4'd2}, 5'd0, " R11");
    issue({2'b00, 1'b1, 5'd4, 4'd2}, 5'd0, " R11");
    issue({2'b00, 1'b0, 5'd4, 4'd3}, 5'd0, " R11");
    drain(2);
    // R10: stall with a pending write-back
    issue({2'b00, 1'b1, 5'd5, 4'd5}, 5'd0, " R10 stall");
    for (int i = 0; i < 3; i++) step(1'b1, {2'b00, 1'b1, 5'd5, 4'd1}, 5'd0, 1'b0, " R10", acc);
    drain(3);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(($urandom % 4) != 0, rfield(int'($urandom % 5), r), 5'($urandom),
           ($urandom % 3) != 0, "", acc);
    end
    drain(3);
    for (int i = 0; i < 32; i++)
      chk(rf[i] == mrf[i], "R9", "file contents", rf[i], mrf[i]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule